// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block sits on the processor side of a narrow external bus and turns single read or write requests into timed bus cycles. A request arrives on a local interface as a 16-bit address, an 8-bit write byte, a direction flag and a memory/IO select. The block then runs one access on a bus whose upper address byte has dedicated pins. The lower address byte shares eight bidirectional pins with the data. An address latch strobe tells an external latch when the shared pins carry address.

Every access walks the phases T1, T2 and T3 in order. T1 presents the address. T2 asserts the read or write strobe. T3 completes the transfer. A READY input sampled while the strobe is active can insert any number of wait phases between T2 and T3. When the access finishes, the block raises a one-cycle completion pulse and, for reads, presents the byte it captured from the shared pins.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, and whenever no access is in progress, busy is 0. The latch strobe is 0, both active-low strobes are 1, the completion pulse is 0, and the block does not drive the shared pins.
- R2: In the first cycle after a request is accepted (T1), the latch strobe is 1 for exactly that one cycle. The upper pins carry address bits 15..8 and the shared pins carry address bits 7..0. Both strobes are 1 during T1.
- R3: The memory/IO line is 0 for a memory access and 1 for an I/O access. It keeps its value from T1 until the access ends.
- R4: In a read, the read strobe is 0 from T2 through T3 and the write strobe stays 1. The block stops driving the shared pins for as long as the read strobe is 0.
- R5: In a read, the byte on the shared pins at the clock edge that ends T3 is captured. It appears on the read-data output in the following cycle, which is also the cycle of the completion pulse.
- R6: In a write, the write byte is driven on the shared pins and the write strobe is 0 from T2 through T3. The read strobe stays 1, and the shared pins do not change while the write strobe is 0.
- R7: The read strobe and the write strobe are never 0 in the same cycle.
- R8: READY is sampled at the clock edge that ends T2 and at the edge that ends each wait phase. A 0 adds one wait phase with the same pin levels as T2. T3 follows the first phase in which READY is sampled as 1.
- R9: A request (req high) is taken only while idle, and busy is 1 from T1 through T3. A request raised during an access is ignored. The completion pulse lasts exactly one cycle and comes in the cycle after T3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request an access (taken only while idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Byte to write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte captured by the last read |
| bus_addr_hi_o | output | 8 | Upper address byte pins |
| bus_ad_io | inout | 8 | Shared lower-address / data pins |
| bus_ale_o | output | 1 | Address latch strobe, active high |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_iom_o | output | 1 | 0 = memory access, 1 = I/O access |
| bus_ready_i | input | 1 | Target ready; 0 inserts wait phases |

## Verification
The assertions assume that the target drives the shared pins only while the read strobe is low. They also assume that READY is synchronous to the clock and settled before each sampling edge. The bench target follows both rules: it gates its driver on the read strobe and changes READY only on falling clock edges. Requests are changed on falling edges as well. Some requests are deliberately raised in the middle of an access, which lets the bench check that a request outside the idle state is ignored without breaking those input rules.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4
  } phase_e;

  typedef struct packed {
    logic ale;
    logic rd_n;
    logic wr_n;
    logic oe;
    logic sel_data;
  } pinctl_t;

  // Phase successor; READY matters only while a strobe is waiting on it.
  function automatic phase_e next_phase(phase_e cur, logic go, logic rdy);
    phase_e nxt;
    case (cur)
      ST_IDLE: nxt = go ? ST_T1 : ST_IDLE;
      ST_T1:   nxt = ST_T2;
      ST_T2,
      ST_TW:   nxt = rdy ? ST_T3 : ST_TW;
      ST_T3:   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Pin levels for a phase and a direction.
  function automatic pinctl_t decode_pins(phase_e cur, logic is_write);
    pinctl_t c;
    c = '{ale: 1'b0, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0, sel_data: 1'b0};
    case (cur)
      ST_T1: begin
        c.ale = 1'b1;
        c.oe  = 1'b1;
      end
      ST_T2, ST_TW, ST_T3: begin
        if (is_write) begin
          c.wr_n     = 1'b0;
          c.oe       = 1'b1;
          c.sel_data = 1'b1;
        end else begin
          c.rd_n = 1'b0;
        end
      end
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic in_strobe_window(phase_e cur);
    return (cur == ST_T2) || (cur == ST_TW);
  endfunction

endpackage

// File: rtl/mbm_fsm.sv
module mbm_fsm
  import mbm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_i,
  input  logic   ready_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   finish_o,
  output logic   ready_window_o
);

  phase_e phase_q;

  assign accept_o       = (phase_q == ST_IDLE) && req_i;
  assign finish_o       = (phase_q == ST_T3);
  assign ready_window_o = in_strobe_window(phase_q);
  assign phase_o        = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= ST_IDLE;
    else        phase_q <= next_phase(phase_q, req_i, ready_i);
  end

endmodule

// File: rtl/mbm_reqhold.sv
module mbm_reqhold #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              finish_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ad_in_i,
  output logic              write_o,
  output logic              io_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_o <= 1'b0;
      io_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else if (accept_i) begin
      write_o <= req_write_i;
      io_o    <= req_io_i;
      addr_o  <= req_addr_i;
      wdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i && !write_o) rdata_o <= ad_in_i;
    end
  end

endmodule

// File: rtl/mbm_padmux.sv
module mbm_padmux #(
  parameter int DATA_W = 8
) (
  input  logic              oe_i,
  input  logic              sel_data_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  inout  wire  [DATA_W-1:0] pad_io,
  output logic [DATA_W-1:0] pad_in_o
);

  logic [DATA_W-1:0] out_val;
  assign out_val = sel_data_i ? wdata_i : addr_lo_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_pad
    assign pad_io[b] = oe_i ? out_val[b] : 1'bz;
  end

  assign pad_in_o = pad_io;

endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic                     req_write_i,
  input  logic                     req_io_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic [ADDR_W-DATA_W-1:0] bus_addr_hi_o,
  inout  wire  [DATA_W-1:0]        bus_ad_io,
  output logic                     bus_ale_o,
  output logic                     bus_rd_n_o,
  output logic                     bus_wr_n_o,
  output logic                     bus_iom_o,
  input  logic                     bus_ready_i
);

  localparam int HI_W = ADDR_W - DATA_W;

  phase_e            phase;
  logic              accept;
  logic              finish;
  logic              ready_window;
  logic              hold_write;
  logic              hold_io;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_wdata;
  logic [DATA_W-1:0] pad_in;
  pinctl_t           pins;
  logic              pad_oe;

  mbm_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .ready_i       (bus_ready_i),
    .phase_o       (phase),
    .accept_o      (accept),
    .finish_o      (finish),
    .ready_window_o(ready_window)
  );

  mbm_reqhold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .finish_i   (finish),
    .req_write_i(req_write_i),
    .req_io_i   (req_io_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .ad_in_i    (pad_in),
    .write_o    (hold_write),
    .io_o       (hold_io),
    .addr_o     (hold_addr),
    .wdata_o    (hold_wdata),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  assign pins   = decode_pins(phase, hold_write);
  assign pad_oe = pins.oe;

  mbm_padmux #(.DATA_W(DATA_W)) u_pad (
    .oe_i      (pad_oe),
    .sel_data_i(pins.sel_data),
    .addr_lo_i (hold_addr[DATA_W-1:0]),
    .wdata_i   (hold_wdata),
    .pad_io    (bus_ad_io),
    .pad_in_o  (pad_in)
  );

  assign busy_o        = (phase != ST_IDLE);
  assign bus_ale_o     = pins.ale;
  assign bus_rd_n_o    = pins.rd_n;
  assign bus_wr_n_o    = pins.wr_n;
  assign bus_iom_o     = hold_io;
  assign bus_addr_hi_o = hold_addr[ADDR_W-1:ADDR_W-HI_W];

endmodule

// File: rtl/mbm_chk.sv
module mbm_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     done,
  input logic                     ale,
  input logic                     rd_n,
  input logic                     wr_n,
  input logic                     iom,
  input logic                     ready,
  input logic [ADDR_W-DATA_W-1:0] addr_hi,
  input logic [DATA_W-1:0]        ad,
  input logic                     pad_oe,
  input logic                     cur_write,
  input logic                     ready_window
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && rd_n && wr_n && !pad_oe));

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  assert_iom_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(iom));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !pad_oe);

  assert_write_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && cur_write) |=> !wr_n);

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(ad));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_window && !ready) |=>
      ($stable(rd_n) && $stable(wr_n) && $stable(addr_hi) && !ale && busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mux_bus_master mbm_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_o),
  .done        (done_o),
  .ale         (bus_ale_o),
  .rd_n        (bus_rd_n_o),
  .wr_n        (bus_wr_n_o),
  .iom         (bus_iom_o),
  .ready       (bus_ready_i),
  .addr_hi     (bus_addr_hi_o),
  .ad          (bus_ad_io),
  .pad_oe      (pad_oe),
  .cur_write   (hold_write),
  .ready_window(ready_window)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic        req_io = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        busy, done;
  logic [7:0]  rdata;
  logic [7:0]  addr_hi;
  wire  [7:0]  ad_w;
  logic        ale, rd_n, wr_n, iom;
  logic        ready = 1'b1;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mux_bus_master i_mux_bus_master (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .req_write_i  (req_write),
    .req_io_i     (req_io),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .busy_o       (busy),
    .done_o       (done),
    .rdata_o      (rdata),
    .bus_addr_hi_o(addr_hi),
    .bus_ad_io    (ad_w),
    .bus_ale_o    (ale),
    .bus_rd_n_o   (rd_n),
    .bus_wr_n_o   (wr_n),
    .bus_iom_o    (iom),
    .bus_ready_i  (ready)
  );

  // Target model: an external latch plus a byte source keyed on the address.
  logic [15:0] lat_addr = '0;
  logic        lat_iom = 1'b0;
  logic [7:0]  wcap = '0;

  function automatic logic [7:0] tgt_byte(logic [15:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'hA5;
  endfunction

  assign ad_w = (!rd_n) ? tgt_byte(lat_addr) : 8'bz;

  typedef struct {
    bit          wr;
    bit          io;
    logic [15:0] addr;
    logic [7:0]  data;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string rq, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // Monitor: latch address, capture writes, score completions.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) begin
        lat_addr = {addr_hi, ad_w};
        lat_iom  = iom;
      end
      if (!wr_n) wcap = ad_w;
      if (done) begin
        if (sb.size() == 0) begin
          check("R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check("R2 latched address", lat_addr, e.addr);
          check("R3 memory/io line", lat_iom, e.io);
          if (e.wr) check("R6 written byte", wcap, e.data);
          else      check("R5 read data", rdata, tgt_byte(e.addr));
        end
      end
    end
  end

  task automatic access(input bit wr, input bit io, input logic [15:0] a,
                        input logic [7:0] d, input int waits, input bit spur);
    exp_t e;
    @(negedge clk);
    req = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = d;
    e.wr = wr; e.io = io; e.addr = a; e.data = d;
    sb.push_back(e);
    // T1
    @(negedge clk);
    req = 1'b0;
    ready = (waits == 0);
    check("R2 ale in T1", ale, 1);
    check("R2 upper address", addr_hi, a[15:8]);
    check("R2 lower address on shared pins", ad_w, a[7:0]);
    check("R2 strobes idle in T1", {rd_n, wr_n}, 2'b11);
    check("R3 io line in T1", iom, io);
    check("R9 busy in T1", busy, 1);
    // T2
    @(negedge clk);
    if (spur) begin
      req = 1'b1; req_addr = ~a; req_write = ~wr;
    end
    check("R2 ale low after T1", ale, 0);
    if (wr) begin
      check("R6 write strobe in T2", {rd_n, wr_n}, 2'b10);
      check("R6 write byte in T2", ad_w, d);
    end else begin
      check("R4 read strobe in T2", {rd_n, wr_n}, 2'b01);
    end
    // wait phases
    for (int w = 0; w < waits; w++) begin
      @(negedge clk);
      req = 1'b0;
      ready = (w == waits - 1);
      check("R8 wait phase strobes", {ale, rd_n, wr_n}, wr ? 3'b010 : 3'b001);
      check("R8 wait phase address", addr_hi, a[15:8]);
      check("R3 io line held in wait", iom, io);
      if (wr) check("R6 write byte held in wait", ad_w, d);
    end
    // T3
    @(negedge clk);
    req = 1'b0;
    ready = 1'b1;
    check("R8 T3 strobes", {ale, rd_n, wr_n}, wr ? 3'b010 : 3'b001);
    check("R9 busy in T3", busy, 1);
    check("R9 no done in T3", done, 0);
    if (wr) check("R6 write byte in T3", ad_w, d);
    // completion
    @(negedge clk);
    check("R9 done after T3", done, 1);
    check("R1 idle after access", {busy, ale, rd_n, wr_n}, 4'b0011);
    check("R7 strobes released", rd_n & wr_n, 1);
    @(negedge clk);
    check("R9 done single cycle", done, 0);
    check("R9 stray request ignored", {busy, ale}, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy, 0);
    check("R1 reset pins", {ale, rd_n, wr_n, done}, 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {busy, ale, rd_n, wr_n, done}, 5'b00110);

    access(0, 0, 16'h1234, 8'h00, 0, 0);
    access(1, 0, 16'hABCD, 8'h3C, 0, 0);
    access(0, 1, 16'h00FF, 8'h00, 2, 0);
    access(1, 1, 16'hFF00, 8'hC3, 3, 0);
    access(0, 0, 16'h5A5A, 8'h00, 1, 1);
    access(1, 0, 16'h8001, 8'h7E, 1, 1);
    access(0, 1, 16'h4321, 8'h00, 5, 0);
    access(1, 0, 16'h0000, 8'hFF, 0, 1);

    check("R9 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule